// File: doc/BRIEF.md
# Rewindable FIFO with Half-Full Status

A single-clock first-in/first-out buffer holding 512 words of 9 bits. Writers present a word with a write enable and readers pull words with a read enable. Internal circular pointers produce every storage address, so no address ever crosses the interface. The ninth bit carries no special meaning and is free for parity or control. Three active-low status outputs report empty, full and more-than-half-full. All three are registered, and they change on the same clock edge as the occupancy they describe.

A rewind input, active low, returns the read side to storage location zero and recomputes occupancy from the write pointer. Everything written since reset can then be read out again in its original order. This is useful for replaying a short message after a receiver reports an error. Rewind is defined only while fewer than 512 words have been written since reset.

Top module: `rewind_fifo`

## Requirements
- R1: While reset is held and after it is released, with no access, empty_n is 0, full_n is 1, half_n is 1 and rd_data is 0.
- R2: Words leave in the order they were written. rd_data takes the read word one clock after the edge that accepts a read, and it holds its value on every edge that accepts no read.
- R3: A write presented while full_n is 0 is ignored: no stored word changes and full_n stays 0.
- R4: A read presented while empty_n is 0 is ignored: the read pointer does not move and rd_data holds its value.
- R5: When a read and a write are both accepted on one edge, occupancy is unchanged. At full only the read is accepted, and at empty only the write is accepted.
- R6: half_n is 0 exactly when the buffer holds at least 257 words, and it is 1 at 256 words.
- R7: full_n is 0 exactly at 512 words and empty_n is 0 exactly at 0 words. Both are never 0 together, and each flag updates on the edge that accepts the access.
- R8: An edge with retx_n low sets the read pointer to location 0 and sets occupancy to the number of words written since reset. A read presented on that edge is ignored, and the next reads replay the data from the first word.
- R9: The pointers wrap past location 511 back to 0, and ordering holds across the wrap during long streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released synchronously |
| wr_en | input | 1 | Write enable, sampled on the rising edge |
| wr_data | input | 9 | Word to store |
| rd_en | input | 1 | Read enable, sampled on the rising edge |
| retx_n | input | 1 | Active-low rewind of the read side |
| rd_data | output | 9 | Registered read word |
| empty_n | output | 1 | Low when no words are stored |
| full_n | output | 1 | Low when 512 words are stored |
| half_n | output | 1 | Low when 257 or more words are stored |

## Verification
The assertions take for granted that rewind is used only while fewer than 512 words have been written since reset. Past that point the recomputed occupancy would alias and the pointer and occupancy properties would no longer describe a meaningful state. The stimulus therefore issues rewind only in a phase that starts from reset and writes a dozen words. The fill-to-full, wrap-around and mixed-traffic phases never pulse retx_n. All inputs change on the falling clock edge, so every sampled value is stable around the rising edge.

// File: rtl/rewind_fifo_pkg.sv
`timescale 1ns/1ps
package rewind_fifo_pkg;

  // How the occupancy count moves on one edge
  typedef enum logic [1:0] {
    OCC_HOLD   = 2'd0,
    OCC_INC    = 2'd1,
    OCC_DEC    = 2'd2,
    OCC_REWIND = 2'd3
  } occ_op_t;

endpackage

// File: rtl/rewind_fifo_rstsync.sv
`timescale 1ns/1ps
module rewind_fifo_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rewind_fifo_ctrl.sv
`timescale 1ns/1ps
module rewind_fifo_ctrl
  import rewind_fifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned OCC_W = ADDR_W + 1,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              retx_n,
  input  logic              full_n,
  input  logic              empty_n,
  output logic              wr_ok,
  output logic              rd_ok,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic [ADDR_W-1:0] rd_ptr,
  output logic [OCC_W-1:0]  occ,
  output logic [OCC_W-1:0]  occ_next
);

  localparam logic [OCC_W-1:0] OCC_MAX = OCC_W'(DEPTH);

  logic [ADDR_W-1:0] wr_ptr_d;
  logic [ADDR_W-1:0] rd_ptr_d;
  occ_op_t           occ_op;

  // Acceptance: the registered flags gate the strobes, rewind blocks reads
  assign wr_ok = wr_en & full_n;
  assign rd_ok = rd_en & empty_n & retx_n;

  always_comb begin
    wr_ptr_d = wr_ptr + ADDR_W'(wr_ok);
    if (!retx_n) rd_ptr_d = '0;
    else         rd_ptr_d = rd_ptr + ADDR_W'(rd_ok);
  end

  always_comb begin
    if (!retx_n) begin
      occ_op = OCC_REWIND;
    end else begin
      case ({wr_ok, rd_ok})
        2'b10:   occ_op = OCC_INC;
        2'b01:   occ_op = OCC_DEC;
        default: occ_op = OCC_HOLD;
      endcase
    end
  end

  always_comb begin
    case (occ_op)
      OCC_INC:    occ_next = occ + OCC_W'(1);
      OCC_DEC:    occ_next = occ - OCC_W'(1);
      OCC_REWIND: occ_next = {1'b0, wr_ptr_d};
      default:    occ_next = occ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      occ    <= occ_next;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_MAX); // R3
  AST_FULL_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wr_ptr)); // R3
  AST_EMPTY_READ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && rd_en && retx_n) |=> $stable(rd_ptr)); // R4
  AST_BOTH_HOLD_OCC: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full_n && rd_en && empty_n && retx_n) |=> $stable(occ)); // R5
  AST_REWIND_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !retx_n |=> (rd_ptr == '0)); // R8

endmodule

// File: rtl/rewind_fifo_flags.sv
`timescale 1ns/1ps
module rewind_fifo_flags #(
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned OCC_W = ADDR_W + 1,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned HALF_LEVEL = DEPTH / 2 + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_next,
  output logic             full_n,
  output logic             empty_n,
  output logic             half_n
);

  localparam logic [OCC_W-1:0] FULL_LVL = OCC_W'(DEPTH);
  localparam logic [OCC_W-1:0] HALF_LVL = OCC_W'(HALF_LEVEL);

  logic full_n_d;
  logic empty_n_d;
  logic half_n_d;

  always_comb begin
    full_n_d  = (occ_next != FULL_LVL);
    empty_n_d = (occ_next != '0);
    half_n_d  = (occ_next < HALF_LVL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_n  <= 1'b1;
      empty_n <= 1'b0;
      half_n  <= 1'b1;
    end else begin
      full_n  <= full_n_d;
      empty_n <= empty_n_d;
      half_n  <= half_n_d;
    end
  end

  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!full_n && !empty_n)); // R7
  AST_FULL_IMPLIES_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !half_n); // R6

endmodule

// File: rtl/rewind_fifo_store.sv
`timescale 1ns/1ps
module rewind_fifo_store #(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned ADDR_W = 9,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_ok,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rd_data_d;

  // Storage array: no reset, written only on an accepted write
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr] <= wr_data;
  end

  always_comb begin
    if (rd_ok) rd_data_d = mem[rd_addr];
    else       rd_data_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_data_d;
  end

endmodule

// File: rtl/rewind_fifo.sv
`timescale 1ns/1ps
module rewind_fifo #(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              retx_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);

  localparam int unsigned OCC_W = ADDR_W + 1;
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [OCC_W-1:0] HALF_LVL = OCC_W'(DEPTH / 2 + 1);

  logic              rst_sync_n;
  logic              wr_ok;
  logic              rd_ok;
  logic [ADDR_W-1:0] wr_ptr;
  logic [ADDR_W-1:0] rd_ptr;
  logic [OCC_W-1:0]  occ;
  logic [OCC_W-1:0]  occ_next;

  rewind_fifo_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rewind_fifo_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .retx_n   (retx_n),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .wr_ok    (wr_ok),
    .rd_ok    (rd_ok),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .occ      (occ),
    .occ_next (occ_next)
  );

  rewind_fifo_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .occ_next (occ_next),
    .full_n   (full_n),
    .empty_n  (empty_n),
    .half_n   (half_n)
  );

  rewind_fifo_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_ok   (wr_ok),
    .wr_addr (wr_ptr),
    .wr_data (wr_data),
    .rd_ok   (rd_ok),
    .rd_addr (rd_ptr),
    .rd_data (rd_data)
  );

  AST_EMPTY_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    empty_n == (occ != '0)); // R7
  AST_FULL_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    full_n == (occ != OCC_W'(DEPTH))); // R7
  AST_HALF_TRACKS_OCC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    half_n == (occ < HALF_LVL)); // R6
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!rd_en || !empty_n || !retx_n) |=> $stable(rd_data)); // R2

endmodule

// File: tb/rewind_fifo_test.sv
`timescale 1ns/1ps
module rewind_fifo_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       rd_en;
  logic       retx_n;
  logic [8:0] wr_data;
  logic [8:0] rd_data;
  logic       empty_n;
  logic       full_n;
  logic       half_n;

  always #10 clk = ~clk;

  rewind_fifo uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .retx_n  (retx_n),
    .rd_data (rd_data),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Behavioural model
  logic [8:0] mdl [512];
  int         wp, rp, cnt;
  logic [8:0] last;
  logic [15:0] lf;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic flags_chk();
    chk(full_n === (cnt != 512), "R7 full_n", int'(full_n), int'(cnt != 512));
    chk(empty_n === (cnt != 0), "R7 empty_n", int'(empty_n), int'(cnt != 0));
    chk(half_n === (cnt < 257), "R6 half_n", int'(half_n), int'(cnt < 257));
  endtask

  task automatic idle();
    wr_en = 1'b0; rd_en = 1'b0; retx_n = 1'b1; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    wp = 0; rp = 0; cnt = 0; last = '0;
    repeat (2) @(negedge clk);
    chk(empty_n === 1'b0, "R1 empty_n in reset", int'(empty_n), 0);
    chk(full_n === 1'b1, "R1 full_n in reset", int'(full_n), 1);
    chk(half_n === 1'b1, "R1 half_n in reset", int'(half_n), 1);
    chk(rd_data === 9'd0, "R1 rd_data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(empty_n === 1'b0 && full_n === 1'b1 && half_n === 1'b1, "R1 flags after release",
        int'({empty_n, full_n, half_n}), 3);
    chk(rd_data === 9'd0, "R1 rd_data after release", int'(rd_data), 0);
  endtask

  task automatic step(input bit w, input logic [8:0] d, input bit r, input bit rt,
                      input string tag);
    bit wacc, racc;
    logic [8:0] e;
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; retx_n = !rt;
    wacc = w && (cnt < 512);
    racc = r && (cnt > 0) && !rt;
    @(posedge clk);
    #1;
    e = last;
    if (racc) begin e = mdl[rp]; rp = (rp + 1) % 512; end
    if (wacc) begin mdl[wp] = d; wp = (wp + 1) % 512; end
    if (rt) begin rp = 0; cnt = wp; end
    else cnt = cnt + int'(wacc) - int'(racc);
    last = e;
    chk(rd_data === e, tag, int'(rd_data), int'(e));
    flags_chk();
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    do_reset();

    // R4: read at empty is ignored, output holds
    step(0, 9'd0, 1, 0, "R4 read while empty");
    chk(empty_n === 1'b0, "R4 still empty", int'(empty_n), 0);

    // Fill to the half threshold
    for (int i = 0; i < 256; i++) step(1, 9'((i * 7 + 3) % 512), 0, 0, "R2 fill");
    chk(half_n === 1'b1, "R6 at 256 words", int'(half_n), 1);
    step(1, 9'h101, 0, 0, "R2 fill");
    chk(half_n === 1'b0, "R6 at 257 words", int'(half_n), 0);
    for (int i = 257; i < 512; i++) step(1, 9'((i * 13 + 5) % 512), 0, 0, "R2 fill");
    chk(full_n === 1'b0, "R7 full at 512", int'(full_n), 0);

    // R3: write at full ignored
    step(1, 9'h1AA, 0, 0, "R3 write while full");
    chk(full_n === 1'b0, "R3 still full", int'(full_n), 0);

    // R5: both at full, only the read goes through
    step(1, 9'h155, 1, 0, "R5 read at full");
    chk(full_n === 1'b1, "R5 full clears", int'(full_n), 1);
    step(1, 9'h0F0, 1, 0, "R5 both accepted");
    chk(cnt == 511 && full_n === 1'b1, "R5 count held at 511", int'(full_n), 1);

    // Drain: ordering check also exposes any overwrite from R3
    while (cnt > 0) step(0, 9'd0, 1, 0, "R2 drain");
    chk(empty_n === 1'b0, "R7 empty after drain", int'(empty_n), 0);

    // R5: both at empty, only the write goes through
    step(1, 9'h033, 1, 0, "R5 read at empty blocked");
    chk(empty_n === 1'b1, "R5 write at empty accepted", int'(empty_n), 1);
    step(0, 9'd0, 1, 0, "R2 read back");

    // R8: rewind and replay
    do_reset();
    for (int i = 0; i < 12; i++) step(1, 9'(40 + i * 3), 0, 0, "R2 load");
    for (int i = 0; i < 7; i++) step(0, 9'd0, 1, 0, "R2 partial read");
    step(0, 9'd0, 1, 1, "R8 read during rewind ignored");
    step(0, 9'd0, 0, 1, "R8 rewind held");
    for (int i = 0; i < 12; i++) step(0, 9'd0, 1, 0, "R8 replay");
    chk(empty_n === 1'b0, "R8 empty after replay", int'(empty_n), 0);

    // R9: long stream crossing the wrap point
    do_reset();
    for (int i = 0; i < 100; i++) step(1, 9'(i), 0, 0, "R2 preload");
    for (int i = 0; i < 1500; i++) step(1, 9'((i * 37 + 11) % 512), 1, 0, "R9 wrap stream");
    chk(cnt == 100, "R9 occupancy after wrap", cnt, 100);

    // Mixed traffic
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[11:3], lf[14], 0, "R2 mixed");
    end
    while (cnt > 0) step(0, 9'd0, 1, 0, "R2 final drain");

    @(negedge clk);
    idle();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule